// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Automatic Refill

This block translates 32-bit virtual addresses into physical addresses through a small, fully associative table of recently used page mappings. Every slot holds a virtual page number, the address space number of the task that owns it, and the matching physical page number. A lookup compares the key against all slots at once. The 12-bit page offset is not translated and is copied into the result.

When no slot matches, the block sends a request to an external page-table port and waits for its response. A valid response is written into a slot, and the lookup runs again. That second search always hits. An invalid response produces a page-fault result and leaves the table unchanged. A flush input empties the table. A mode input selects how task switches are handled. In tagged mode, matching compares the stored address space number with the current one. In flush mode, tags are ignored and the table is emptied whenever the requesting address space changes.

Top module: `asn_tlb`

## Requirements
- R1: A lookup that hits produces `res_valid` in the cycle after it is accepted, with `res_fault` low and `res_paddr` equal to the slot's physical page number concatenated with the offset.
- R2: Bits [11:0] of `res_paddr` equal bits [11:0] of the accepted `lk_vaddr` in every non-fault result.
- R3: With `asn_mode` high, a slot matches only when both its virtual page number and its address space number equal the key. At most one slot ever matches.
- R4: On a miss the block raises `pt_req` and carries the page number and address space number on `pt_vpn`/`pt_asn`. It holds `pt_req` until `pt_rsp_valid`. After an accepted response with `pt_rsp_ok` high, the result follows two cycles after the response cycle, using `pt_rsp_ppn`.
- R5: A response with `pt_rsp_ok` low gives `res_valid` with `res_fault` high and `res_paddr` zero one cycle later, and writes no slot, so a repeated lookup misses again.
- R6: A refill goes to the lowest-numbered empty slot. When every slot is full, it goes to a round-robin pointer that starts at 0, advances by one on every refill and wraps.
- R7: `lk_ready` is low from the cycle after a miss is accepted until the result has been produced, and high otherwise.
- R8: A `flush` pulse empties all slots from the next cycle on. A lookup accepted in the same cycle still sees the old contents.
- R9: With `asn_mode` low, address space numbers are ignored during matching. An accepted lookup whose address space number differs from the previously accepted one empties the table first and is handled as a miss.
- R10: After reset, `res_valid` and `pt_req` are low, `lk_ready` is high and every slot is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all slots |
| asn_mode | input | 1 | 1: match on address space tag; 0: flush on address space change |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Block can accept a lookup |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asn | input | 8 | Address space number of the requester |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | 32 | Translated physical address (zero on fault) |
| res_fault | output | 1 | Page fault: page table had no valid entry |
| pt_req | output | 1 | Page-table request, held until response |
| pt_vpn | output | 20 | Virtual page number being requested |
| pt_asn | output | 8 | Address space number being requested |
| pt_rsp_valid | input | 1 | Page-table response strobe |
| pt_rsp_ok | input | 1 | Response carries a valid mapping |
| pt_rsp_ppn | input | 20 | Physical page number from the page table |

## Verification
Some properties are checked on every cycle: that no key matches two slots, that a request is held until its response, that the retry after a refill hits, that the block refuses lookups while a request is open, that a fault follows only a negative response, that an empty slot is preferred for refill and that a flush clears the table. Other behaviour only the bench scenarios can show. These are exact result latencies, the round-robin eviction order after the table fills, separation of two tasks using the same page, the difference between same-cycle and next-cycle flush, and the switch-triggered emptying in flush mode that ignores tags.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RETRY = 2'd2
  } tlb_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASN_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASN_W-1:0]   key_asn,
  input  logic               use_asn,
  input  logic               flush_all,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASN_W-1:0]   wr_asn,
  input  logic [PPN_W-1:0]   wr_ppn,
  output logic [ENTRIES-1:0] vld_vec,
  output logic [ENTRIES-1:0] match_vec,
  output logic               hit,
  output logic [PPN_W-1:0]   hit_ppn
);
  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [ASN_W-1:0]   asn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  // valid bits: a write to a slot wins over a flush in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (flush_all) vld_q <= '0;
      if (wr_en)     vld_q[wr_idx] <= 1'b1;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx] <= wr_vpn;
      asn_q[wr_idx] <= wr_asn;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = vld_q[g] && (vpn_q[g] == key_vpn) &&
                          (!use_asn || (asn_q[g] == key_asn));
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
    end
  end

  assign hit     = |match_vec;
  assign vld_vec = vld_q;

  p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (flush_all && !wr_en) |=> (vld_vec == '0));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] vld_vec,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;

  always_ff @(posedge clk) begin
    if (rst)          rr_q <= '0;
    else if (advance) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  // priority: existing match, then lowest empty slot, then round robin
  always_comb begin
    victim_idx = rr_q;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_vec[i]) victim_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) victim_idx = IDX_W'(i);
    end
  end

  p_victim_free_r6: assert property (@(posedge clk) disable iff (rst)
    (!(&vld_vec) && !(|match_vec)) |-> !vld_vec[victim_idx]);
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ASN_W   = 8,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asn_mode,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_ready,
  input  logic              pt_rsp_valid,
  input  logic              pt_rsp_ok,
  input  logic [VPN_W-1:0]  pt_rsp_ppn,
  output logic              pt_req,
  output logic [VPN_W-1:0]  pt_vpn,
  output logic [ASN_W-1:0]  pt_asn,
  input  logic              cam_hit,
  input  logic [VPN_W-1:0]  cam_ppn,
  input  logic [IDX_W-1:0]  victim_idx,
  output logic [VPN_W-1:0]  key_vpn,
  output logic [ASN_W-1:0]  key_asn,
  output logic              switch_flush,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [VPN_W-1:0]  wr_vpn,
  output logic [ASN_W-1:0]  wr_asn,
  output logic [VPN_W-1:0]  wr_ppn,
  output logic              res_valid,
  output logic [VA_W-1:0]   res_paddr,
  output logic              res_fault
);
  tlb_state_e       state_q;
  logic [VPN_W-1:0] sv_vpn;
  logic [OFF_W-1:0] sv_off;
  logic [ASN_W-1:0] sv_asn;
  logic [ASN_W-1:0] cur_asn;
  logic             idle, accept;

  assign idle     = (state_q == ST_IDLE);
  assign lk_ready = idle;
  assign accept   = idle && lk_valid;

  // search key: live request while idle, saved request afterwards
  assign key_vpn = idle ? lk_vaddr[VA_W-1:OFF_W] : sv_vpn;
  assign key_asn = idle ? lk_asn : sv_asn;

  assign switch_flush = accept && !asn_mode && (lk_asn != cur_asn);

  assign wr_en  = (state_q == ST_WAIT) && pt_rsp_valid && pt_rsp_ok;
  assign wr_idx = victim_idx;
  assign wr_vpn = sv_vpn;
  assign wr_asn = sv_asn;
  assign wr_ppn = pt_rsp_ppn;

  assign pt_vpn = sv_vpn;
  assign pt_asn = sv_asn;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sv_vpn    <= '0;
      sv_off    <= '0;
      sv_asn    <= '0;
      cur_asn   <= '0;
      pt_req    <= 1'b0;
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (lk_valid) begin
            sv_vpn  <= lk_vaddr[VA_W-1:OFF_W];
            sv_off  <= lk_vaddr[OFF_W-1:0];
            sv_asn  <= lk_asn;
            cur_asn <= lk_asn;
            if (cam_hit && !switch_flush) begin
              res_valid <= 1'b1;
              res_fault <= 1'b0;
              res_paddr <= {cam_ppn, lk_vaddr[OFF_W-1:0]};
            end else begin
              pt_req  <= 1'b1;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (pt_rsp_valid) begin
            pt_req <= 1'b0;
            if (pt_rsp_ok) begin
              state_q <= ST_RETRY;
            end else begin
              res_valid <= 1'b1;
              res_fault <= 1'b1;
              res_paddr <= '0;
              state_q   <= ST_IDLE;
            end
          end
        end
        ST_RETRY: begin
          res_valid <= 1'b1;
          res_fault <= 1'b0;
          res_paddr <= {cam_ppn, sv_off};
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pt_req && !pt_rsp_valid) |=> pt_req);

  p_retry_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RETRY) |-> cam_hit);

  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    pt_req |-> !lk_ready);

  p_fault_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> $past(pt_rsp_valid && !pt_rsp_ok));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ASN_W   = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             asn_mode,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             res_valid,
  output logic [VA_W-1:0]  res_paddr,
  output logic             res_fault,
  output logic             pt_req,
  output logic [VPN_W-1:0] pt_vpn,
  output logic [ASN_W-1:0] pt_asn,
  input  logic             pt_rsp_valid,
  input  logic             pt_rsp_ok,
  input  logic [VPN_W-1:0] pt_rsp_ppn
);
  logic [VPN_W-1:0]   key_vpn, wr_vpn, wr_ppn, cam_ppn;
  logic [ASN_W-1:0]   key_asn, wr_asn;
  logic               switch_flush, wr_en, cam_hit;
  logic [IDX_W-1:0]   wr_idx, victim_idx;
  logic [ENTRIES-1:0] vld_vec, match_vec;

  tlb_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .ASN_W(ASN_W), .ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rst(rst), .asn_mode(asn_mode),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asn(lk_asn), .lk_ready(lk_ready),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_ok(pt_rsp_ok), .pt_rsp_ppn(pt_rsp_ppn),
    .pt_req(pt_req), .pt_vpn(pt_vpn), .pt_asn(pt_asn),
    .cam_hit(cam_hit), .cam_ppn(cam_ppn), .victim_idx(victim_idx),
    .key_vpn(key_vpn), .key_asn(key_asn), .switch_flush(switch_flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asn(wr_asn), .wr_ppn(wr_ppn),
    .res_valid(res_valid), .res_paddr(res_paddr), .res_fault(res_fault)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W), .ASN_W(ASN_W)) u_cam (
    .clk(clk), .rst(rst), .key_vpn(key_vpn), .key_asn(key_asn), .use_asn(asn_mode),
    .flush_all(flush | switch_flush), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_asn(wr_asn), .wr_ppn(wr_ppn),
    .vld_vec(vld_vec), .match_vec(match_vec), .hit(cam_hit), .hit_ppn(cam_ppn)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .vld_vec(vld_vec), .match_vec(match_vec),
    .advance(wr_en), .victim_idx(victim_idx)
  );
endmodule

// File: tb/asn_tlb_bench.sv
`timescale 1ns/1ps
module asn_tlb_bench;
  localparam int LAT = 28;  // responder: response LAT cycles after request

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0, asn_mode = 1'b1;
  logic        lk_valid = 1'b0, lk_ready;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asn = '0;
  logic        res_valid, res_fault;
  logic [31:0] res_paddr;
  logic        pt_req;
  logic [19:0] pt_vpn;
  logic [7:0]  pt_asn;
  logic        pt_rsp_valid = 1'b0, pt_rsp_ok = 1'b0;
  logic [19:0] pt_rsp_ppn = '0;

  int tests = 0, fails = 0;
  bit busy_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  asn_tlb #(.ENTRIES(4)) u_asn_tlb (
    .clk(clk), .rst(rst), .flush(flush), .asn_mode(asn_mode),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr), .lk_asn(lk_asn),
    .res_valid(res_valid), .res_paddr(res_paddr), .res_fault(res_fault),
    .pt_req(pt_req), .pt_vpn(pt_vpn), .pt_asn(pt_asn),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_ok(pt_rsp_ok), .pt_rsp_ppn(pt_rsp_ppn)
  );

  // page table model: faults when top nibble of vpn is F
  function automatic logic [19:0] pt_map(input logic [19:0] v, input logic [7:0] a);
    return v ^ {a, 12'h000} ^ 20'h30000;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (pt_req) begin
        repeat (LAT - 1) @(negedge clk);
        pt_rsp_valid = 1'b1;
        pt_rsp_ok    = (pt_vpn[19:16] != 4'hF);
        pt_rsp_ppn   = pt_map(pt_vpn, pt_asn);
        @(negedge clk);
        pt_rsp_valid = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [7:0] a, input logic [31:0] va, input bit fl,
                        output logic [31:0] pa, output bit flt, output int cyc);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_asn = a; flush = fl;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0; flush = 1'b0;
    cyc = 1;
    while (!res_valid && cyc < 200) begin
      if (lk_ready) busy_err = 1;
      @(negedge clk);
      cyc++;
    end
    pa = res_paddr; flt = res_fault;
  endtask

  task automatic expect_lk(input string tag, input logic [7:0] a, input logic [7:0] pta,
                           input logic [31:0] va, input bit fl, input int ecyc, input bit efl);
    logic [31:0] pa, epa;
    bit flt;
    int cyc;
    lookup(a, va, fl, pa, flt, cyc);
    epa = efl ? 32'h0 : {pt_map(va[31:12], pta), va[11:0]};
    check(cyc == ecyc, {tag, " latency"}, cyc, ecyc);
    check(flt == efl, {tag, " fault"}, flt, efl);
    check(pa == epa, {tag, " paddr"}, pa, epa);
    if (!efl) check(pa[11:0] == va[11:0], "R2 offset", pa[11:0], va[11:0]);
  endtask

  // {asn[46:39], vaddr[38:7], cycles[6:1], fault[0]}; ENTRIES=4
  localparam int NV = 14;
  localparam logic [46:0] VEC [NV] = '{
    {8'd1, 32'h0000_1123, 6'd30, 1'b0},  // miss -> slot0
    {8'd1, 32'h0000_1FFF, 6'd1,  1'b0},  // hit
    {8'd2, 32'h0000_1004, 6'd30, 1'b0},  // other ASN misses -> slot1
    {8'd1, 32'h0000_1010, 6'd1,  1'b0},
    {8'd2, 32'h0000_1020, 6'd1,  1'b0},
    {8'd1, 32'hF000_3000, 6'd29, 1'b1},  // fault
    {8'd1, 32'hF000_3ABC, 6'd29, 1'b1},  // still absent
    {8'd1, 32'h0000_2000, 6'd30, 1'b0},  // slot2
    {8'd1, 32'h0000_3000, 6'd30, 1'b0},  // slot3, rr wraps to 0
    {8'd1, 32'h0000_4000, 6'd30, 1'b0},  // evicts slot0
    {8'd1, 32'h0000_1000, 6'd30, 1'b0},  // evicts slot1
    {8'd2, 32'h0000_1000, 6'd30, 1'b0},  // evicts slot2
    {8'd1, 32'h0000_3000, 6'd1,  1'b0},  // slot3 survives
    {8'd1, 32'h0000_4000, 6'd1,  1'b0}
  };

  function automatic string vtag(input int i, input int cyc, input bit f);
    if (f) return "R5";
    if (i >= 9 && i <= 12) return "R6";
    if (i >= 2 && i <= 4) return "R3";
    return (cyc == 1) ? "R1" : "R4";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R10 res_valid", res_valid, 0);
    check(pt_req == 1'b0, "R10 pt_req", pt_req, 0);
    check(lk_ready == 1'b1, "R10 lk_ready", lk_ready, 1);

    for (int i = 0; i < NV; i++) begin
      expect_lk(vtag(i, int'(VEC[i][6:1]), VEC[i][0]), VEC[i][46:39], VEC[i][46:39],
                VEC[i][38:7], 1'b0, int'(VEC[i][6:1]), VEC[i][0]);
    end
    check(busy_err == 0, "R7 ready during refill", busy_err, 0);

    // R8: same-cycle lookup sees old contents, next one misses
    expect_lk("R8 same-cycle", 8'd1, 8'd1, 32'h0000_3111, 1'b1, 1, 1'b0);
    expect_lk("R8 after flush", 8'd1, 8'd1, 32'h0000_3222, 1'b0, 30, 1'b0);

    // R9: tag ignored in flush mode; ASN change empties table
    expect_lk("R9 prep", 8'd2, 8'd2, 32'h0000_5000, 1'b0, 30, 1'b0);
    @(negedge clk); asn_mode = 1'b0;
    expect_lk("R9 tag ignored", 8'd2, 8'd1, 32'h0000_3333, 1'b0, 1, 1'b0);
    expect_lk("R9 switch", 8'd7, 8'd7, 32'h0000_3444, 1'b0, 30, 1'b0);
    expect_lk("R9 same asn", 8'd7, 8'd7, 32'h0000_3555, 1'b0, 1, 1'b0);
    expect_lk("R9 other page gone", 8'd9, 8'd9, 32'h0000_3666, 1'b0, 30, 1'b0);
    check(busy_err == 0, "R7 ready final", busy_err, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule